// File: doc/BRIEF.md
# Multi-Class Oldest-First Issue Selector

This block sits between a set of per-class ready queues and the execution stage of an out-of-order core. Five classes are served: integer, floating point, branch, memory and miscellaneous. Every class queue is age-ordered and shows the block a short window of its oldest entries. Each entry carries a sequence number, a squashed flag and a payload. Within one clock the block chooses up to `W` instructions, oldest first across all classes. It keeps to a separate per-cycle quota for each class except miscellaneous, and it throws away squashed entries it meets along the way.

The selection is a chain of `STAGES` combinational passes. Each pass either drops one squashed head or issues one instruction. Every pass sees the windows as already consumed by the passes before it. The chosen instructions fill the issue bundle from slot 0 upward. For each class the block reports how many entries it consumed, so the queue owner can pop them. The bundle size is the number of queue credits returned. Running totals of issues per class and of dropped squashed heads are kept in registers.

Top module: `issue_sel`

## Requirements
- R1: At most `W` (default 4) instructions issue per cycle. They occupy bundle slots 0 to `bnd_size`-1 with no gaps, and every slot from `bnd_size` upward has its valid bit low.
- R2: Integer, floating point, branch and memory issue at most 2, 1, 1 and 2 instructions per cycle by default. A class that has reached its quota takes no further part in the cycle, even if it holds the oldest entry.
- R3: The miscellaneous class has no quota of its own. It can fill the whole bundle.
- R4: In each pass, the eligible head with the smallest sequence number issues. Sequence numbers are compared as unsigned values with no wrap.
- R5: When sequence numbers are equal, the class that comes earlier in the order integer(0), float(1), branch(2), memory(3), misc(4) wins. The numbers in brackets are the class codes reported in `bnd_cls`.
- R6: If any eligible class has a squashed head, the first such class in the R5 order has that head popped. The pass issues nothing, and the drop is counted in `stall_cnt`. A squashed head in a class that is at its quota is left in place.
- R7: `pop_cnt` gives, per class in 3-bit fields (class c at bits 3c+2..3c), the number of issued entries plus dropped entries. `bnd_size` is the number of queue credits returned.
- R8: On each clock edge without reset, `stat_iss` (32 bits per class, class c at bits 32c+31..32c) adds that cycle's per-class issue counts, and `stat_stall` adds `stall_cnt`.
- R9: A synchronous active-low reset clears every statistics counter. Selection itself is purely combinational and does not depend on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_cnt | input | 15 | Valid entries in each class window, 3 bits per class |
| q_seq | input | 320 | Sequence numbers, 16 bits per entry, entry k of class c at index 4c+k |
| q_sqsh | input | 20 | Squashed flag per window entry, same indexing |
| q_data | input | 320 | Payload per window entry, 16 bits, same indexing |
| bnd_valid | output | 4 | Valid bit per bundle slot |
| bnd_cls | output | 12 | Class code per slot, 3 bits each |
| bnd_seq | output | 64 | Sequence number per slot |
| bnd_data | output | 64 | Payload per slot |
| bnd_size | output | 3 | Instructions issued this cycle, equal to credits returned |
| pop_cnt | output | 15 | Entries consumed per class, 3 bits each |
| stall_cnt | output | 4 | Squashed heads dropped this cycle |
| stat_iss | output | 160 | Running issue count per class, 32 bits each |
| stat_stall | output | 32 | Running count of dropped squashed heads |

## Verification
The age-order assertion assumes that the entries inside each class window have non-decreasing sequence numbers. The pop bound assumes that no `q_cnt` field exceeds the window depth of four. Every stimulus vector in the bench is written to respect both, with ties used only across different classes. Inputs change only at the falling edge and are then held through the rising edge, so the combinational bundle is stable whenever the clocked properties sample it.

// File: rtl/iss_pkg.sv
// Shared definitions for the issue selector.
// Assumes five instruction classes, and that their order here is the tie-break order.
package iss_pkg;
    localparam int NCLS  = 5;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_INT  = 3'd0,
        CL_FP   = 3'd1,
        CL_BR   = 3'd2,
        CL_MEM  = 3'd3,
        CL_MISC = 3'd4
    } cls_e;
endpackage

// File: rtl/iss_pass.sv
// One select pass of the issue chain.
// Looks at the current head of each class window. If an eligible head is
// squashed, it drops the first one in class order. Otherwise it issues the
// oldest eligible head. It returns the updated consumption state for the
// next pass.
// Assumes q_cnt fields never exceed LOOK.
module iss_pass
    import iss_pkg::*;
#(
    parameter int LOOK   = 4,
    parameter int SEQ_W  = 16,
    parameter int DATA_W = 16,
    parameter int W      = 4,
    parameter int CW     = $clog2(LOOK + 1),
    parameter int IW     = $clog2(W + 1),
    parameter logic [NCLS*IW-1:0] LIMS = '0
) (
    input  logic [NCLS*CW-1:0]          q_cnt,
    input  logic [NCLS*LOOK*SEQ_W-1:0]  q_seq,
    input  logic [NCLS*LOOK-1:0]        q_sqsh,
    input  logic [NCLS*LOOK*DATA_W-1:0] q_data,
    input  logic [NCLS*CW-1:0]          ptr_i,
    input  logic [NCLS*IW-1:0]          iss_i,
    input  logic [IW-1:0]               tot_i,
    output logic [NCLS*CW-1:0]          ptr_o,
    output logic [NCLS*IW-1:0]          iss_o,
    output logic [IW-1:0]               tot_o,
    output logic                        fire_o,
    output logic                        drop_o,
    output logic [CLS_W-1:0]            cls_o,
    output logic [SEQ_W-1:0]            seq_o,
    output logic [DATA_W-1:0]           data_o
);
    logic [NCLS-1:0]   has;
    logic [NCLS-1:0]   elig;
    logic [NCLS-1:0]   hsq;
    logic [SEQ_W-1:0]  hseq [NCLS];
    logic [DATA_W-1:0] hdat [NCLS];
    logic              drop_hit;
    logic              found;
    int                dsel;
    int                wsel;
    logic [SEQ_W-1:0]  best;

    // Fetch each class head and decide whether the class may take part.
    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            has[c]  = (ptr_i[c*CW +: CW] < q_cnt[c*CW +: CW]) &&
                      (int'(ptr_i[c*CW +: CW]) < LOOK);
            hseq[c] = has[c] ? q_seq[(c*LOOK + int'(ptr_i[c*CW +: CW]))*SEQ_W +: SEQ_W] : '0;
            hdat[c] = has[c] ? q_data[(c*LOOK + int'(ptr_i[c*CW +: CW]))*DATA_W +: DATA_W] : '0;
            hsq[c]  = has[c] && q_sqsh[c*LOOK + int'(ptr_i[c*CW +: CW])];
            elig[c] = has[c] && (iss_i[c*IW +: IW] < LIMS[c*IW +: IW]) && (tot_i < IW'(W));
        end
    end

    // Find a squashed head to drop, then the oldest head, with earlier classes winning ties.
    always_comb begin
        drop_hit = 1'b0;
        dsel     = 0;
        found    = 1'b0;
        wsel     = 0;
        best     = '1;
        for (int c = 0; c < NCLS; c++) begin
            if (!drop_hit && elig[c] && hsq[c]) begin
                drop_hit = 1'b1;
                dsel     = c;
            end
        end
        for (int c = 0; c < NCLS; c++) begin
            if (elig[c] && (!found || hseq[c] < best)) begin
                found = 1'b1;
                best  = hseq[c];
                wsel  = c;
            end
        end
    end

    // Produce the consumption state that the next pass will see.
    always_comb begin
        ptr_o  = ptr_i;
        iss_o  = iss_i;
        tot_o  = tot_i;
        fire_o = 1'b0;
        drop_o = 1'b0;
        cls_o  = CLS_W'(wsel);
        seq_o  = best;
        data_o = hdat[wsel];
        if (drop_hit) begin
            ptr_o[dsel*CW +: CW] = ptr_i[dsel*CW +: CW] + CW'(1);
            drop_o = 1'b1;
        end else if (found) begin
            ptr_o[wsel*CW +: CW] = ptr_i[wsel*CW +: CW] + CW'(1);
            iss_o[wsel*IW +: IW] = iss_i[wsel*IW +: IW] + IW'(1);
            tot_o  = tot_i + IW'(1);
            fire_o = 1'b1;
        end
    end
endmodule

// File: rtl/iss_stats.sv
// Running statistics for the issue selector.
// Adds the per-class issue counts and the count of dropped squashed heads
// every cycle. Assumes the counters may wrap.
module iss_stats
    import iss_pkg::*;
#(
    parameter int IW    = 3,
    parameter int SW    = 4,
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCLS*IW-1:0]      iss,
    input  logic [SW-1:0]           stall,
    output logic [NCLS*CNT_W-1:0]   stat_iss,
    output logic [CNT_W-1:0]        stat_stall
);
    // Accumulate this cycle's counts, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_iss   <= '0;
            stat_stall <= '0;
        end else begin
            for (int c = 0; c < NCLS; c++) begin
                stat_iss[c*CNT_W +: CNT_W] <= stat_iss[c*CNT_W +: CNT_W] + CNT_W'(iss[c*IW +: IW]);
            end
            stat_stall <= stat_stall + CNT_W'(stall);
        end
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_chk
        AST_STAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stat_iss[c*CNT_W +: CNT_W] ==
                $past(stat_iss[c*CNT_W +: CNT_W]) + CNT_W'($past(iss[c*IW +: IW]))); // R8
    end
    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stat_stall == $past(stat_stall) + CNT_W'($past(stall))); // R8
endmodule

// File: rtl/issue_sel.sv
// Multi-class oldest-first issue selector (top).
// Chains STAGES select passes inside one clock. Every pass either drops a
// squashed head or issues one instruction into the next bundle slot.
// Assumes each class window is age-ordered and that q_cnt <= LOOK.
module issue_sel
    import iss_pkg::*;
#(
    parameter int LOOK    = 4,
    parameter int SEQ_W   = 16,
    parameter int DATA_W  = 16,
    parameter int W       = 4,
    parameter int STAGES  = 8,
    parameter int LIM_INT = 2,
    parameter int LIM_FP  = 1,
    parameter int LIM_BR  = 1,
    parameter int LIM_MEM = 2,
    parameter int CNT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCLS*$clog2(LOOK+1)-1:0] q_cnt,
    input  logic [NCLS*LOOK*SEQ_W-1:0]    q_seq,
    input  logic [NCLS*LOOK-1:0]          q_sqsh,
    input  logic [NCLS*LOOK*DATA_W-1:0]   q_data,
    output logic [W-1:0]                  bnd_valid,
    output logic [W*CLS_W-1:0]            bnd_cls,
    output logic [W*SEQ_W-1:0]            bnd_seq,
    output logic [W*DATA_W-1:0]           bnd_data,
    output logic [$clog2(W+1)-1:0]        bnd_size,
    output logic [NCLS*$clog2(LOOK+1)-1:0] pop_cnt,
    output logic [$clog2(STAGES+1)-1:0]   stall_cnt,
    output logic [NCLS*CNT_W-1:0]         stat_iss,
    output logic [CNT_W-1:0]              stat_stall
);
    localparam int CW = $clog2(LOOK + 1);
    localparam int IW = $clog2(W + 1);
    localparam int SW = $clog2(STAGES + 1);
    localparam logic [NCLS*IW-1:0] LIMS =
        {IW'(W), IW'(LIM_MEM), IW'(LIM_BR), IW'(LIM_FP), IW'(LIM_INT)};

    logic [STAGES-1:0] fire_s;
    logic [STAGES-1:0] drop_s;
    logic [CLS_W-1:0]  cls_s  [STAGES];
    logic [SEQ_W-1:0]  seq_s  [STAGES];
    logic [DATA_W-1:0] data_s [STAGES];
    logic [IW-1:0]     slot_s [STAGES];
    logic [NCLS*IW-1:0] iss_fin;

    for (genvar s = 0; s < STAGES; s++) begin : g_st
        logic [NCLS*CW-1:0] ptr_in, ptr_out;
        logic [NCLS*IW-1:0] iss_in, iss_out;
        logic [IW-1:0]      tot_in, tot_out;
        if (s == 0) begin : g_head
            assign ptr_in = '0;
            assign iss_in = '0;
            assign tot_in = '0;
        end else begin : g_link
            assign ptr_in = g_st[s-1].ptr_out;
            assign iss_in = g_st[s-1].iss_out;
            assign tot_in = g_st[s-1].tot_out;
        end
        iss_pass #(
            .LOOK(LOOK), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .W(W),
            .CW(CW), .IW(IW), .LIMS(LIMS)
        ) u_pass (
            .q_cnt(q_cnt), .q_seq(q_seq), .q_sqsh(q_sqsh), .q_data(q_data),
            .ptr_i(ptr_in), .iss_i(iss_in), .tot_i(tot_in),
            .ptr_o(ptr_out), .iss_o(iss_out), .tot_o(tot_out),
            .fire_o(fire_s[s]), .drop_o(drop_s[s]), .cls_o(cls_s[s]),
            .seq_o(seq_s[s]), .data_o(data_s[s])
        );
        assign slot_s[s] = tot_in;
    end

    assign bnd_size = g_st[STAGES-1].tot_out;
    assign pop_cnt  = g_st[STAGES-1].ptr_out;
    assign iss_fin  = g_st[STAGES-1].iss_out;

    // Place each issuing pass's entry into the slot it was given.
    always_comb begin
        bnd_valid = '0;
        bnd_cls   = '0;
        bnd_seq   = '0;
        bnd_data  = '0;
        for (int s = 0; s < STAGES; s++) begin
            if (fire_s[s] && int'(slot_s[s]) < W) begin
                bnd_valid[int'(slot_s[s])] = 1'b1;
                bnd_cls[int'(slot_s[s])*CLS_W +: CLS_W]   = cls_s[s];
                bnd_seq[int'(slot_s[s])*SEQ_W +: SEQ_W]   = seq_s[s];
                bnd_data[int'(slot_s[s])*DATA_W +: DATA_W] = data_s[s];
            end
        end
    end

    // Count the passes that dropped a squashed head.
    always_comb begin
        stall_cnt = '0;
        for (int s = 0; s < STAGES; s++) begin
            stall_cnt = stall_cnt + SW'(drop_s[s]);
        end
    end

    iss_stats #(.IW(IW), .SW(SW), .CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .iss(iss_fin), .stall(stall_cnt),
        .stat_iss(stat_iss), .stat_stall(stat_stall)
    );

    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_size <= IW'(W)); // R1
    for (genvar k = 0; k < W; k++) begin : g_slot_chk
        AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
            bnd_valid[k] == (k < int'(bnd_size))); // R1
    end
    for (genvar k = 0; k < W - 1; k++) begin : g_age_chk
        AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            bnd_valid[k+1] |-> bnd_seq[k*SEQ_W +: SEQ_W] <= bnd_seq[(k+1)*SEQ_W +: SEQ_W]); // R4
    end
    for (genvar c = 0; c < NCLS - 1; c++) begin : g_cap_chk
        AST_CLASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            iss_fin[c*IW +: IW] <= LIMS[c*IW +: IW]); // R2
    end
    for (genvar c = 0; c < NCLS; c++) begin : g_pop_chk
        AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            pop_cnt[c*CW +: CW] <= q_cnt[c*CW +: CW]); // R7
    end
endmodule

// File: tb/sim_issue_sel.sv
// Bench for issue_sel: table of vectors, then directed reset checks.
module sim_issue_sel;
    import iss_pkg::*;

    localparam int LOOK = 4, SEQ_W = 16, DATA_W = 16, W = 4, CNT_W = 32;
    localparam int CW = 3, IW = 3, SW = 4;

    typedef struct packed {
        logic [2:0]  cnt;
        logic [3:0]  sq;
        logic [31:0] sb;
    } qd_t;

    typedef struct packed {
        qd_t [4:0]   q;
        logic [2:0]  size;
        logic [31:0] eseq;
        logic [11:0] ecls;
        logic [14:0] epop;
        logic [3:0]  estall;
    } vec_t;

    function automatic qd_t mq(input logic [2:0] n, input logic [3:0] s, input logic [31:0] b);
        qd_t r;
        r.cnt = n;
        r.sq  = s;
        r.sb  = b;
        return r;
    endfunction

    localparam qd_t QE = '0;
    localparam int NV = 9;
    // q is {misc, mem, br, fp, int}; eseq byte k / ecls field k is slot k; epop field c is class c.
    localparam vec_t VEC [NV] = '{
        '{q: {QE, mq(1,0,32'h04), mq(1,0,32'h03), mq(1,0,32'h02), mq(2,0,32'h0501)},
          size: 3'd4, eseq: 32'h04030201, ecls: {3'd3,3'd2,3'd1,3'd0},
          epop: {3'd0,3'd1,3'd1,3'd1,3'd1}, estall: 4'd0},
        '{q: {QE, QE, QE, QE, mq(4,0,32'h04030201)},
          size: 3'd2, eseq: 32'h00000201, ecls: {3'd0,3'd0,3'd0,3'd0},
          epop: {3'd0,3'd0,3'd0,3'd0,3'd2}, estall: 4'd0},
        '{q: {mq(4,0,32'h04030201), QE, QE, QE, mq(1,0,32'h05)},
          size: 3'd4, eseq: 32'h04030201, ecls: {3'd4,3'd4,3'd4,3'd4},
          epop: {3'd4,3'd0,3'd0,3'd0,3'd0}, estall: 4'd0},
        '{q: {mq(1,0,32'h07), mq(1,0,32'h07), mq(1,0,32'h07), mq(1,0,32'h07), mq(1,0,32'h07)},
          size: 3'd4, eseq: 32'h07070707, ecls: {3'd3,3'd2,3'd1,3'd0},
          epop: {3'd0,3'd1,3'd1,3'd1,3'd1}, estall: 4'd0},
        '{q: {mq(1,0,32'h06), QE, mq(1,0,32'h04), mq(1,4'b0001,32'h02), mq(2,4'b0001,32'h0301)},
          size: 3'd3, eseq: 32'h00060403, ecls: {3'd0,3'd4,3'd2,3'd0},
          epop: {3'd1,3'd0,3'd1,3'd1,3'd2}, estall: 4'd2},
        '{q: {QE, QE, QE, mq(1,0,32'h03), mq(3,4'b0100,32'h050201)},
          size: 3'd3, eseq: 32'h00030201, ecls: {3'd0,3'd1,3'd0,3'd0},
          epop: {3'd0,3'd0,3'd0,3'd1,3'd2}, estall: 4'd0},
        '{q: {mq(1,0,32'h07), mq(3,0,32'h030201), mq(2,0,32'h0504), mq(1,0,32'h06), QE},
          size: 3'd4, eseq: 32'h06040201, ecls: {3'd1,3'd2,3'd3,3'd3},
          epop: {3'd0,3'd2,3'd1,3'd1,3'd0}, estall: 4'd0},
        '{q: {QE, QE, QE, QE, QE},
          size: 3'd0, eseq: 32'h0, ecls: 12'h0,
          epop: 15'h0, estall: 4'd0},
        '{q: {mq(1,0,32'h09), QE, QE, QE, mq(4,4'b1111,32'h04030201)},
          size: 3'd1, eseq: 32'h00000009, ecls: {3'd0,3'd0,3'd0,3'd4},
          epop: {3'd1,3'd0,3'd0,3'd0,3'd4}, estall: 4'd4}
    };

    logic                          clk;
    logic                          rst_n;
    logic [NCLS*CW-1:0]            q_cnt;
    logic [NCLS*LOOK*SEQ_W-1:0]    q_seq;
    logic [NCLS*LOOK-1:0]          q_sqsh;
    logic [NCLS*LOOK*DATA_W-1:0]   q_data;
    logic [W-1:0]                  bnd_valid;
    logic [W*CLS_W-1:0]            bnd_cls;
    logic [W*SEQ_W-1:0]            bnd_seq;
    logic [W*DATA_W-1:0]           bnd_data;
    logic [IW-1:0]                 bnd_size;
    logic [NCLS*CW-1:0]            pop_cnt;
    logic [SW-1:0]                 stall_cnt;
    logic [NCLS*CNT_W-1:0]         stat_iss;
    logic [CNT_W-1:0]              stat_stall;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;
    int exp_st [NCLS];
    int exp_stall = 0;

    issue_sel u0 (
        .clk(clk), .rst_n(rst_n), .q_cnt(q_cnt), .q_seq(q_seq), .q_sqsh(q_sqsh),
        .q_data(q_data), .bnd_valid(bnd_valid), .bnd_cls(bnd_cls), .bnd_seq(bnd_seq),
        .bnd_data(bnd_data), .bnd_size(bnd_size), .pop_cnt(pop_cnt),
        .stall_cnt(stall_cnt), .stat_iss(stat_iss), .stat_stall(stat_stall)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        for (int c = 0; c < NCLS; c++) begin
            q_cnt[c*CW +: CW] = v.q[c].cnt;
            for (int k = 0; k < LOOK; k++) begin
                logic [SEQ_W-1:0] sv;
                sv = {8'h00, v.q[c].sb[8*k +: 8]};
                q_sqsh[c*LOOK + k] = v.q[c].sq[k];
                q_seq[(c*LOOK + k)*SEQ_W +: SEQ_W] = sv;
                q_data[(c*LOOK + k)*DATA_W +: DATA_W] = DATA_W'((c + 1) * 4096) + sv;
            end
        end
    endtask

    task automatic check_vec(input int n, input vec_t v);
        logic [W-1:0] mask;
        mask = W'((1 << int'(v.size)) - 1);
        chk(bnd_size == v.size, $sformatf("R1 R2 R3 vec %0d bundle size", n), 64'(bnd_size), 64'(v.size));
        chk(bnd_valid == mask, $sformatf("R1 vec %0d slot valid mask", n), 64'(bnd_valid), 64'(mask));
        for (int k = 0; k < int'(v.size); k++) begin
            logic [SEQ_W-1:0]  es;
            logic [2:0]        ec;
            logic [DATA_W-1:0] ed;
            es = {8'h00, v.eseq[8*k +: 8]};
            ec = v.ecls[3*k +: 3];
            ed = DATA_W'((int'(ec) + 1) * 4096) + es;
            chk(bnd_seq[k*SEQ_W +: SEQ_W] == es, $sformatf("R4 vec %0d slot %0d seq", n, k),
                64'(bnd_seq[k*SEQ_W +: SEQ_W]), 64'(es));
            chk(bnd_cls[k*CLS_W +: CLS_W] == ec, $sformatf("R5 vec %0d slot %0d class", n, k),
                64'(bnd_cls[k*CLS_W +: CLS_W]), 64'(ec));
            chk(bnd_data[k*DATA_W +: DATA_W] == ed, $sformatf("R4 vec %0d slot %0d payload", n, k),
                64'(bnd_data[k*DATA_W +: DATA_W]), 64'(ed));
            exp_st[int'(ec)]++;
        end
        chk(pop_cnt == v.epop, $sformatf("R6 R7 vec %0d pop counts", n), 64'(pop_cnt), 64'(v.epop));
        chk(stall_cnt == v.estall, $sformatf("R6 vec %0d stall count", n), 64'(stall_cnt), 64'(v.estall));
        exp_stall += int'(v.estall);
    endtask

    task automatic check_stats(input string tag);
        for (int c = 0; c < NCLS; c++) begin
            chk(stat_iss[c*CNT_W +: CNT_W] == CNT_W'(exp_st[c]),
                $sformatf("%s class %0d issue total", tag, c),
                64'(stat_iss[c*CNT_W +: CNT_W]), 64'(exp_st[c]));
        end
        chk(stat_stall == CNT_W'(exp_stall), $sformatf("%s stall total", tag),
            64'(stat_stall), 64'(exp_stall));
    endtask

    initial begin
        for (int c = 0; c < NCLS; c++) exp_st[c] = 0;
        rst_n = 1'b0;
        drive(VEC[7]);
        repeat (3) @(negedge clk);
        #5;
        check_stats("R9 after reset");
        chk(bnd_size == '0, "R1 empty queues at reset", 64'(bnd_size), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(VEC[v]);
            #5;
            check_vec(v, VEC[v]);
        end
        @(negedge clk);
        #5;
        check_stats("R8 accumulated");

        // Reset in the middle of traffic clears the totals but not the selection.
        drive(VEC[0]);
        rst_n = 1'b0;
        @(negedge clk);
        #5;
        for (int c = 0; c < NCLS; c++) exp_st[c] = 0;
        exp_stall = 0;
        check_stats("R9 mid-run reset");
        chk(bnd_size == 3'd4, "R9 selection during reset", 64'(bnd_size), 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        for (int c = 0; c < 4; c++) exp_st[c] = 1;
        check_stats("R8 first cycle after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule